// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer with Address-Space Tags

This block maps 32-bit virtual addresses onto physical addresses at 4 KB page granularity. Every slot holds a tag word and a data word. The tag word is a virtual page number plus a 6-bit address-space tag. The data word is a physical frame number plus four flags: non-cacheable, dirty, valid and global. A lookup compares the page number and the current address-space tag against every slot in parallel. Within the same cycle it returns a physical address, a hit flag and a two-bit fault code.

A small set of control registers surrounds the slot array:

- an index register
- a free-running victim counter
- staging copies of the tag and data words
- a fault-address register
- a page-table context register

Software fills slots through three commands: store at the index register, store at the victim counter, and search for the staged tag. When a lookup faults, the fault-address, staged-tag and context registers are loaded on the next clock edge. A trap handler then finds them ready.

Top module: `vxl_tlb`

## Requirements
- R1: While reset is held, the index, staged tag, staged data, context and fault-address registers read 0, and the victim counter reads 63. Every slot is cleared, so a lookup of page 0 with tag 0 finds slot 0 and returns the invalid fault.
- R2: The victim counter (register select 1) decreases by one on every clock. After it shows 8 it shows 63 next, so it always lies in 8..63. A store-at-victim command writes the slot the counter shows in the cycle the command is applied.
- R3: A slot matches when its page number equals address bits 31:12. Its tag (tag word bits 11:6) must also equal the lookup tag, unless the slot's global flag (data bit 8) is set. When several slots match, the lowest-numbered one is used.
- R4: On a hit, `xl_hit` is 1, `xl_fault` is 0, and `xl_paddr` is the frame number (data bits 31:12) followed by address bits 11:0, all within the same cycle.
- R5: The fault codes are 1 for no match, 2 for a match whose valid flag (data bit 9) is clear, and 3 for a write that matches a valid slot whose dirty flag (data bit 10) is clear.
- R6: After a faulting lookup, the fault-address register (select 4) holds the address. The staged tag (select 5) holds address bits 31:12, then the lookup tag in bits 11:6, then zeros.
- R7: After a faulting lookup, context (select 3) keeps bits 31:21, takes address bits 30:12 into bits 20:2, and clears bits 1:0.
- R8: A register write to context changes bits 31:21 only.
- R9: The store-at-index command (op 1) writes the staged tag and data words into the slot named by index-register bits 13:8.
- R10: The search command (op 3) uses the staged tag with the same matching rule. On a hit it sets the index register to the slot number shifted left by 8. On a miss it sets bit 31 and leaves bits 13:8 unchanged.
- R11: Register writes are masked: the staged tag (select 5) keeps bits 31:6, the staged data (select 2) keeps bits 31:8, and the index (select 0) keeps bits 31 and 13:8. Writes to the victim counter and the fault-address register are ignored.
- R12: With `xl_req` low, `xl_hit` and `xl_fault` are 0 and no fault register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| xl_req | input | 1 | lookup request |
| xl_vaddr | input | 32 | virtual address to translate |
| xl_write | input | 1 | lookup is a store |
| xl_asid | input | 6 | current address-space tag |
| xl_paddr | output | 32 | translated address, 0 when not hit |
| xl_hit | output | 1 | lookup hit |
| xl_fault | output | 2 | 0 none, 1 no match, 2 invalid, 3 modify |
| reg_wr | input | 1 | register write strobe |
| reg_sel | input | 3 | 0 index, 1 victim, 2 data, 3 context, 4 fault address, 5 tag |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | selected register value |
| op_cmd | input | 2 | 0 idle, 1 store at index, 2 store at victim, 3 search |

## Verification
All 64 slots are filled with arithmetic patterns, so the global, valid and dirty flags vary independently across slots. Each slot is then looked up four ways: read and write, each with its own tag and with a foreign tag. This separates a global hit from a tag miss, an invalid slot from an absent one, and a clean-page store from a load. Extra patterns cover the cleared array after reset, two slots carrying the same key (which tells the lowest-index rule apart from any other choice), and store-at-victim writes confirmed by a later search. A walk of the victim counter across its wrap point checks the 8-to-63 step.

// File: rtl/vxl_pkg.sv
// Shared types and field positions for the translation buffer.
// Assumes 32-bit words and a 6-bit address-space tag.
package vxl_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISS    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_MODIFY  = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_WR_IDX  = 2'd1,
        OP_WR_RAND = 2'd2,
        OP_PROBE   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RS_INDEX  = 3'd0,
        RS_RANDOM = 3'd1,
        RS_DATA   = 3'd2,
        RS_CTX    = 3'd3,
        RS_BADVA  = 3'd4,
        RS_TAG    = 3'd5
    } rsel_e;

    localparam int LO_G = 8;
    localparam int LO_V = 9;
    localparam int LO_D = 10;
    localparam int IDX_LSB = 8;
    localparam logic [31:0] TAG_MASK  = 32'hFFFF_FFC0;
    localparam logic [31:0] DATA_MASK = 32'hFFFF_FF00;
    localparam logic [31:0] CTX_BASE  = 32'hFFE0_0000;
endpackage

// File: rtl/vxl_rand_ctr.sv
// Victim counter: counts down from DEPTH-1 to FLOOR and wraps back to DEPTH-1.
// Assumes FLOOR < DEPTH.
module vxl_rand_ctr #(
    parameter int DEPTH = 64,
    parameter int FLOOR = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] rnd_q
);
    localparam logic [IW-1:0] TOP = IW'(DEPTH - 1);
    localparam logic [IW-1:0] BOT = IW'(FLOOR);

    // step the counter once per cycle, wrapping at the floor
    always_ff @(posedge clk) begin
        if (!rst_n)          rnd_q <= TOP;
        else if (rnd_q == BOT) rnd_q <= TOP;
        else                 rnd_q <= rnd_q - 1'b1;
    end
endmodule

// File: rtl/vxl_prio_enc.sv
// Lowest-index-first priority encoder over a match vector.
// Returns index 0 with found low when no bit is set.
module vxl_prio_enc #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/vxl_entry_array.sv
// Slot storage with two parallel compare ports (lookup and search).
// Keeps only the fields the matching and translation use; one write per cycle.
module vxl_entry_array #(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [19:0]      wr_vpn,
    input  logic [5:0]       wr_asid,
    input  logic [19:0]      wr_pfn,
    input  logic             wr_d,
    input  logic             wr_v,
    input  logic             wr_g,
    input  logic [19:0]      lk_vpn,
    input  logic [5:0]       lk_asid,
    input  logic [19:0]      pr_vpn,
    input  logic [5:0]       pr_asid,
    output logic [DEPTH-1:0] lk_match,
    output logic [DEPTH-1:0] pr_match,
    input  logic [IW-1:0]    sel_idx,
    output logic [19:0]      sel_pfn,
    output logic             sel_v,
    output logic             sel_d
);
    logic [DEPTH-1:0][19:0] pfn_all;
    logic [DEPTH-1:0]       v_all;
    logic [DEPTH-1:0]       d_all;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [19:0] vpn_r;
        logic [5:0]  asid_r;
        logic [19:0] pfn_r;
        logic        d_r, v_r, g_r;

        // load this slot when the write targets it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_r <= '0; asid_r <= '0; pfn_r <= '0;
                d_r <= 1'b0; v_r <= 1'b0; g_r <= 1'b0;
            end else if (wr_en && wr_idx == IW'(e)) begin
                vpn_r <= wr_vpn; asid_r <= wr_asid; pfn_r <= wr_pfn;
                d_r <= wr_d; v_r <= wr_v; g_r <= wr_g;
            end
        end

        assign lk_match[e] = (vpn_r == lk_vpn) && (g_r || asid_r == lk_asid);
        assign pr_match[e] = (vpn_r == pr_vpn) && (g_r || asid_r == pr_asid);
        assign pfn_all[e]  = pfn_r;
        assign v_all[e]    = v_r;
        assign d_all[e]    = d_r;
    end

    // read out the fields of the selected slot
    always_comb begin
        sel_pfn = pfn_all[sel_idx];
        sel_v   = v_all[sel_idx];
        sel_d   = d_all[sel_idx];
    end
endmodule

// File: rtl/vxl_tlb.sv
// Fully associative translation buffer top: control registers, fault
// classification, fault register loading and slot maintenance commands.
// Assumes one command per cycle; a lookup fault takes precedence over a
// register write to the same register in the same cycle.
module vxl_tlb
    import vxl_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int RAND_FLOOR  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xl_req,
    input  logic [31:0] xl_vaddr,
    input  logic        xl_write,
    input  logic [5:0]  xl_asid,
    output logic [31:0] xl_paddr,
    output logic        xl_hit,
    output logic [1:0]  xl_fault,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  op_cmd
);
    localparam int IW = $clog2(NUM_ENTRIES);
    localparam logic [31:0] IDX_MASK = 32'h8000_0000 | (32'(NUM_ENTRIES - 1) << IDX_LSB);

    logic [31:0] index_q, tag_q, data_q, ctx_q, badva_q;
    logic [IW-1:0] rnd_q;
    logic [NUM_ENTRIES-1:0] lk_match, pr_match;
    logic lk_found, pr_found;
    logic [IW-1:0] lk_idx, pr_idx, wr_idx;
    logic [19:0] hit_pfn;
    logic hit_v, hit_d, wr_en, fault_take;
    flt_e fault_c;

    vxl_rand_ctr #(.DEPTH(NUM_ENTRIES), .FLOOR(RAND_FLOOR)) i_rand (
        .clk(clk), .rst_n(rst_n), .rnd_q(rnd_q)
    );

    assign wr_en  = (op_cmd == OP_WR_IDX) || (op_cmd == OP_WR_RAND);
    assign wr_idx = (op_cmd == OP_WR_RAND) ? rnd_q : index_q[IDX_LSB +: IW];

    vxl_entry_array #(.DEPTH(NUM_ENTRIES)) i_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(tag_q[31:12]), .wr_asid(tag_q[11:6]),
        .wr_pfn(data_q[31:12]), .wr_d(data_q[LO_D]), .wr_v(data_q[LO_V]), .wr_g(data_q[LO_G]),
        .lk_vpn(xl_vaddr[31:12]), .lk_asid(xl_asid),
        .pr_vpn(tag_q[31:12]), .pr_asid(tag_q[11:6]),
        .lk_match(lk_match), .pr_match(pr_match),
        .sel_idx(lk_idx), .sel_pfn(hit_pfn), .sel_v(hit_v), .sel_d(hit_d)
    );

    vxl_prio_enc #(.N(NUM_ENTRIES)) i_lk_enc (.req(lk_match), .found(lk_found), .idx(lk_idx));
    vxl_prio_enc #(.N(NUM_ENTRIES)) i_pr_enc (.req(pr_match), .found(pr_found), .idx(pr_idx));

    // classify the lookup outcome
    always_comb begin
        if (!xl_req)                fault_c = FLT_NONE;
        else if (!lk_found)         fault_c = FLT_MISS;
        else if (!hit_v)            fault_c = FLT_INVALID;
        else if (xl_write && !hit_d) fault_c = FLT_MODIFY;
        else                        fault_c = FLT_NONE;
    end

    assign fault_take = (fault_c != FLT_NONE);
    assign xl_fault   = fault_c;
    assign xl_hit     = xl_req && lk_found && !fault_take;
    assign xl_paddr   = xl_hit ? {hit_pfn, xl_vaddr[11:0]} : 32'h0;

    // index register: search result or masked software write
    always_ff @(posedge clk) begin
        if (!rst_n)                 index_q <= '0;
        else if (op_cmd == OP_PROBE) index_q <= pr_found ? (32'(pr_idx) << IDX_LSB)
                                                         : (index_q | 32'h8000_0000);
        else if (reg_wr && reg_sel == RS_INDEX) index_q <= reg_wdata & IDX_MASK;
    end

    // staged tag: lookup key on fault, else masked software write
    always_ff @(posedge clk) begin
        if (!rst_n)          tag_q <= '0;
        else if (fault_take) tag_q <= {xl_vaddr[31:12], xl_asid, 6'b0};
        else if (reg_wr && reg_sel == RS_TAG) tag_q <= reg_wdata & TAG_MASK;
    end

    // staged data word: masked software write only
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (reg_wr && reg_sel == RS_DATA) data_q <= reg_wdata & DATA_MASK;
    end

    // fault address: captured on every fault
    always_ff @(posedge clk) begin
        if (!rst_n)          badva_q <= '0;
        else if (fault_take) badva_q <= xl_vaddr;
    end

    // context: base kept, faulting page loaded; software sets base only
    always_ff @(posedge clk) begin
        if (!rst_n)          ctx_q <= '0;
        else if (fault_take) ctx_q <= {ctx_q[31:21], xl_vaddr[30:12], 2'b00};
        else if (reg_wr && reg_sel == RS_CTX)
            ctx_q <= (reg_wdata & CTX_BASE) | (ctx_q & ~CTX_BASE);
    end

    // register read multiplexer
    always_comb begin
        case (reg_sel)
            RS_INDEX:  reg_rdata = index_q;
            RS_RANDOM: reg_rdata = 32'(rnd_q) << IDX_LSB >> IDX_LSB;
            RS_DATA:   reg_rdata = data_q;
            RS_CTX:    reg_rdata = ctx_q;
            RS_BADVA:  reg_rdata = badva_q;
            RS_TAG:    reg_rdata = tag_q;
            default:   reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/vxl_tlb_chk.sv
// Property checker for the translation buffer, bound to the top module.
module vxl_tlb_chk #(
    parameter int NUM_ENTRIES = 64,
    parameter int RAND_FLOOR  = 8,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xl_req,
    input logic [31:0]   xl_vaddr,
    input logic [5:0]    xl_asid,
    input logic          xl_hit,
    input logic [1:0]    xl_fault,
    input logic [IW-1:0] rnd_q,
    input logic [31:0]   ctx_q,
    input logic [31:0]   badva_q,
    input logic [31:0]   tag_q
);
    localparam logic [IW-1:0] TOP = IW'(NUM_ENTRIES - 1);
    localparam logic [IW-1:0] BOT = IW'(RAND_FLOOR);

    AST_RAND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_q == BOT) |=> (rnd_q == TOP)); // R2
    AST_RAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_q != BOT) |=> (rnd_q == IW'($past(rnd_q) - 1'b1))); // R2
    AST_RAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_q >= BOT)); // R2
    AST_HIT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_fault == 2'd0)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |-> (!xl_hit && xl_fault == 2'd0)); // R12
    AST_IDLE_BADVA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_fault == 2'd0) |=> $stable(badva_q)); // R12
    AST_FAULT_BADVA: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_fault != 2'd0) |=> (badva_q == $past(xl_vaddr))); // R6
    AST_FAULT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_fault != 2'd0) |=> (tag_q == {$past(xl_vaddr[31:12]), $past(xl_asid), 6'b0})); // R6
    AST_CTX_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_fault != 2'd0) |=> (ctx_q[31:21] == $past(ctx_q[31:21]))); // R7
    AST_CTX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_fault != 2'd0) |=> (ctx_q[20:0] == {$past(xl_vaddr[30:12]), 2'b00})); // R7
endmodule

bind vxl_tlb vxl_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES), .RAND_FLOOR(RAND_FLOOR)) i_chk (
    .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_asid(xl_asid),
    .xl_hit(xl_hit), .xl_fault(xl_fault), .rnd_q(rnd_q), .ctx_q(ctx_q),
    .badva_q(badva_q), .tag_q(tag_q)
);

// File: tb/test_vxl_tlb.sv
`timescale 1ns/1ps
module test_vxl_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_req = 1'b0, xl_write = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic [5:0]  xl_asid = '0;
    logic [31:0] xl_paddr;
    logic        xl_hit;
    logic [1:0]  xl_fault;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [1:0]  op_cmd = '0;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] ctx_m = '0;

    always #4 clk = ~clk;

    vxl_tlb i_vxl_tlb (
        .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_write(xl_write),
        .xl_asid(xl_asid), .xl_paddr(xl_paddr), .xl_hit(xl_hit), .xl_fault(xl_fault),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .op_cmd(op_cmd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        reg_sel = s; #1; v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1; reg_wr = 1'b0;
    endtask

    task automatic op(input logic [1:0] c);
        op_cmd = c; @(posedge clk); #1; op_cmd = 2'd0;
    endtask

    task automatic put(input int idx, input logic [31:0] hi, input logic [31:0] lo);
        wr(3'd5, hi); wr(3'd2, lo); wr(3'd0, 32'(idx) << 8); op(2'd1);
    endtask

    // lookup with expected outcome, then fault register checks
    task automatic xl_do(input string req, input logic [31:0] va, input logic w,
                         input logic [5:0] asid, input logic [1:0] ef, input logic [31:0] epa);
        logic [31:0] v;
        xl_vaddr = va; xl_write = w; xl_asid = asid; xl_req = 1'b1;
        #1;
        check({req, " fault"}, 32'(xl_fault), 32'(ef));
        check({req, " hit"}, 32'(xl_hit), 32'(ef == 2'd0));
        if (ef == 2'd0) check({req, " paddr"}, xl_paddr, epa);
        @(posedge clk); #1; xl_req = 1'b0;
        if (ef != 2'd0) begin
            ctx_m = {ctx_m[31:21], va[30:12], 2'b00};
            rd(3'd4, v); check("R6 badaddr", v, va);
            rd(3'd5, v); check("R6 tag", v, {va[31:12], asid, 6'b0});
            rd(3'd3, v); check("R7 context", v, ctx_m);
        end
    endtask

    function automatic logic [19:0] p_vpn(int i);  return 20'h40000 | 20'(i * 20'h111); endfunction
    function automatic logic [5:0]  p_asid(int i); return 6'((i * 7) % 64); endfunction
    function automatic logic [19:0] p_pfn(int i);  return 20'h80000 ^ 20'(i * 20'h0305); endfunction
    function automatic logic p_g(int i); return (i % 4) == 0; endfunction
    function automatic logic p_v(int i); return (i % 5) != 1; endfunction
    function automatic logic p_d(int i); return (i % 3) != 2; endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev, r;
        logic [1:0] ef;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        rd(3'd1, v); check("R1 victim", v, 32'd63);
        rd(3'd0, v); check("R1 index", v, 0);
        rd(3'd2, v); check("R1 data", v, 0);
        rd(3'd3, v); check("R1 context", v, 0);
        rd(3'd4, v); check("R1 badaddr", v, 0);
        rd(3'd5, v); check("R1 tag", v, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        xl_do("R1 cleared slot", 32'h0000_0123, 1'b0, 6'd0, 2'd2, 0);
        xl_do("R5 empty miss", 32'h0000_1123, 1'b0, 6'd0, 2'd1, 0);

        // R2: victim counter walk across the wrap
        for (int k = 0; k < 70; k++) begin
            rd(3'd1, prev);
            @(posedge clk); #1;
            rd(3'd1, v);
            check("R2 victim step", v, (prev == 32'd8) ? 32'd63 : prev - 1);
        end

        // R11: register masks and ignored writes
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); check("R11 tag mask", v, 32'hFFFF_FFC0);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R11 data mask", v, 32'hFFFF_FF00);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R11 index mask", v, 32'h8000_3F00);
        rd(3'd4, prev);
        wr(3'd4, 32'h1234_5678); rd(3'd4, v); check("R11 badaddr ignored", v, prev);
        rd(3'd1, prev);
        wr(3'd1, 32'd20); rd(3'd1, v);
        check("R11 victim ignored", v, (prev == 32'd8) ? 32'd63 : prev - 1);
        // R8: context base only
        wr(3'd3, 32'hFFFF_FFFF); ctx_m = 32'hFFE0_0000 | (ctx_m & 32'h001F_FFFF);
        rd(3'd3, v); check("R8 context write", v, ctx_m);

        // R9: fill every slot through the index register
        for (int i = 0; i < 64; i++)
            put(i, {p_vpn(i), p_asid(i), 6'b0},
                {p_pfn(i), 1'b0, p_d(i), p_v(i), p_g(i), 8'h00});

        // R3 R4 R5: sweep of every slot, both directions, own and foreign tag
        for (int i = 0; i < 64; i++) begin
            for (int w = 0; w < 2; w++) begin
                for (int alt = 0; alt < 2; alt++) begin
                    logic [5:0] a;
                    logic [31:0] va;
                    a  = (alt == 1) ? p_asid(i) + 6'd1 : p_asid(i);
                    va = {p_vpn(i), 12'((i * 37) & 12'hFFF)};
                    if (!(p_g(i) || alt == 0)) ef = 2'd1;
                    else if (!p_v(i))          ef = 2'd2;
                    else if (w == 1 && !p_d(i)) ef = 2'd3;
                    else                       ef = 2'd0;
                    xl_do("R3 R4 R5 sweep", va, 1'(w), a, ef, {p_pfn(i), va[11:0]});
                end
            end
            if (i == 20) begin
                wr(3'd3, 32'h1234_5678);
                ctx_m = 32'h1220_0000 | (ctx_m & 32'h001F_FFFF);
                rd(3'd3, v); check("R8 context write keeps page", v, ctx_m);
            end
        end

        // R12: idle lookup touches nothing
        rd(3'd4, prev);
        xl_vaddr = 32'hDEAD_0000; xl_req = 1'b0; #1;
        check("R12 idle hit", 32'(xl_hit), 0);
        check("R12 idle fault", 32'(xl_fault), 0);
        @(posedge clk); #1;
        rd(3'd4, v); check("R12 badaddr held", v, prev);

        // R10: search hit and miss
        wr(3'd5, {p_vpn(13), p_asid(13), 6'b0}); op(2'd3);
        rd(3'd0, v); check("R10 search hit", v, 32'd13 << 8);
        wr(3'd0, 32'h0000_0500);
        wr(3'd5, {p_vpn(13), p_asid(13) + 6'd1, 6'b0}); op(2'd3);
        rd(3'd0, v); check("R10 search miss", v, 32'h8000_0500);

        // R2: store at victim, located by search
        for (int k = 0; k < 3; k++) begin
            wr(3'd5, {20'h3F000 + 20'(k), 6'd9, 6'b0});
            wr(3'd2, {20'h12300 + 20'(k), 12'h600});
            rd(3'd1, r);
            op(2'd2);
            op(2'd3);
            rd(3'd0, v); check("R2 victim store", v, r << 8);
            xl_do("R2 victim hit", {20'h3F000 + 20'(k), 12'h0AB}, 1'b1, 6'd9, 2'd0,
                  {20'h12300 + 20'(k), 12'h0AB});
        end

        // R3: lowest slot wins on a duplicate key
        put(2, {20'h07777, 6'd1, 6'b0}, {20'hAAAAA, 12'h700});
        put(3, {20'h07777, 6'd1, 6'b0}, {20'hBBBBB, 12'h700});
        xl_do("R3 lowest slot", 32'h0777_7010, 1'b0, 6'd40, 2'd0, 32'hAAAA_A010);
        wr(3'd5, {20'h07777, 6'd5, 6'b0}); op(2'd3);
        rd(3'd0, v); check("R3 lowest slot search", v, 32'd2 << 8);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule